// File: doc/BRIEF.md
# Instruction-Boundary Event Arbiter

This block sits beside an in-order core's run loop. At each instruction boundary, once the previous instruction has fully retired, it decides which single event to service before the pipeline moves on. The candidates are, in order: a fault or trap queued from the previous cycle, a machine check, the best external interrupt, and an inter-processor request.

External interrupt sources post requests that the block latches as pending bits. Each source has its own priority level. A pending source is deliverable only when its level is strictly above the core's current priority level. Among deliverable sources the highest level wins, and a tie goes to the lowest source index. The winner's index, level and vector are reported. Its pending bit is dropped at the clock edge that closes the claim cycle.

Taking an interrupt or a machine check does three things in that same cycle: it clears the load-locked reservation, flushes the pipeline and withholds the pipeline-advance enable. While the core runs handler code, every source except the machine check is masked. That includes the inter-processor requests.

Top module: `boundary_irq_ctrl`

## Requirements
- R1: On a boundary cycle with the queued-event flag set, `faultDeliver` is 1 and no other event output is active. In that cycle `advance`, `flush` and `resvClear` are 0.
- R2: On a boundary cycle with no queued event and `mchkReq` high, `mchkTaken` is 1, whether or not handler mode is set.
- R3: A pending source is deliverable only when its level is strictly greater than `curLevel`. While `handlerMode` is 1, no interrupt is claimed and `ipiAck` stays 0.
- R4: When an interrupt is taken, `claimSrc` is the deliverable source with the highest level. Equal levels resolve to the lowest index. `claimLevel` is that source's level and `claimVector` equals VEC_BASE + claimSrc*VEC_STRIDE (defaults 256 and 16). All three are 0 when `intTaken` is 0.
- R5: In a cycle where `intTaken` or `mchkTaken` is 1, `resvClear` and `flush` are 1 and `advance` is 0.
- R6: A claimed source's pending bit is cleared at the end of the claim cycle, so the source is not claimed again unless it is raised anew. A raise of that source in the claim cycle itself keeps it pending.
- R7: Inter-processor requests are considered only when no fault, machine check or interrupt is taken at the boundary, and only outside handler mode. `ipiAck` is one-hot: bit 0 (translation shootdown) wins over bit 1 (barrier synchronization). Taking one leaves `advance` at 1.
- R8: When `boundary` is 0, all event outputs, `flush`, `resvClear` and `advance` are 0, and `srcRaise` pulses are still latched as pending.
- R9: On a boundary cycle with no fault, machine check or interrupt taken, `advance` is 1, and `flush` and `resvClear` are 0.
- R10: Reset clears every pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Previous instruction fully retired, decision cycle |
| queuedEvent | input | 1 | Fault or trap queued from the prior cycle |
| srcRaise | input | NSRC | One-cycle request pulses per interrupt source |
| srcLevel | input | NSRC*LW | Level of each source, source i at bits [i*LW +: LW] |
| curLevel | input | LW | Current interrupt priority level |
| handlerMode | input | 1 | Core is running handler code |
| mchkReq | input | 1 | Machine check request |
| ipiReq | input | 2 | Bit 0 translation shootdown, bit 1 barrier sync |
| faultDeliver | output | 1 | Queued fault delivered this boundary |
| mchkTaken | output | 1 | Machine check taken |
| intTaken | output | 1 | External interrupt claimed |
| claimSrc | output | SW | Claimed source index |
| claimLevel | output | LW | Claimed source level |
| claimVector | output | VW | Claimed source vector |
| ipiAck | output | 2 | One-hot inter-processor request acknowledge |
| resvClear | output | 1 | Clear load-locked reservation |
| flush | output | 1 | Flush pipeline |
| advance | output | 1 | Pipeline-advance enable |

## Verification
The decision outputs are combinational from the inputs and the pending register, so every result is due in the same cycle as the boundary that causes it. The bench drives inputs just after the falling edge and compares one nanosecond later, before the next rising edge. Pending-bit effects of a raise or a claim become visible one cycle later, at the next boundary. The reference model therefore updates its own pending array only after the rising edge that closes the cycle.

// File: rtl/bnd_pkg.sv
package bnd_pkg;
  typedef struct packed {
    logic takeFault;
    logic takeMchk;
    logic takeInt;
    logic takeIpi;
  } bndStrobe_t;

  localparam int IPI_COUNT   = 2;
  localparam int IPI_SHOOT   = 0;
  localparam int IPI_BARRIER = 1;
endpackage

// File: rtl/bnd_datapath.sv
module bnd_datapath
  import bnd_pkg::*;
#(
  parameter int NSRC       = 8,
  parameter int LW         = 5,
  parameter int VW         = 12,
  parameter int VEC_BASE   = 256,
  parameter int VEC_STRIDE = 16,
  parameter int SW         = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NSRC-1:0]      srcRaise,
  input  logic [NSRC*LW-1:0]   srcLevel,
  input  logic [LW-1:0]        curLevel,
  input  logic [IPI_COUNT-1:0] ipiReq,
  input  bndStrobe_t           strobe,
  output logic                 anyDeliverable,
  output logic                 anyIpi,
  output logic [SW-1:0]        claimSrc,
  output logic [LW-1:0]        claimLevel,
  output logic [VW-1:0]        claimVector,
  output logic [IPI_COUNT-1:0] ipiAck
);
  logic [NSRC-1:0] pending;
  logic [NSRC-1:0] deliverable;
  logic [NSRC-1:0] clearMask;
  logic [LW-1:0]   levelOf [NSRC];
  logic [SW-1:0]   bestIdx;
  logic [LW-1:0]   bestLvl;
  logic            bestFound;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign levelOf[i]     = srcLevel[i*LW +: LW];
    assign deliverable[i] = pending[i] && (levelOf[i] > curLevel);
  end

  // Strict compare keeps the lowest index on equal levels.
  always_comb begin
    bestIdx   = '0;
    bestLvl   = '0;
    bestFound = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (deliverable[i] && (!bestFound || levelOf[i] > bestLvl)) begin
        bestIdx   = SW'(i);
        bestLvl   = levelOf[i];
        bestFound = 1'b1;
      end
    end
  end

  assign anyDeliverable = bestFound;
  assign anyIpi         = |ipiReq;

  always_comb begin
    clearMask = '0;
    if (strobe.takeInt) clearMask[bestIdx] = 1'b1;
  end

  // A fresh raise in the claim cycle wins over the clear.
  always_ff @(posedge clk) begin
    if (!rstN) pending <= '0;
    else       pending <= (pending & ~clearMask) | srcRaise;
  end

  always_comb begin
    claimSrc    = '0;
    claimLevel  = '0;
    claimVector = '0;
    if (strobe.takeInt) begin
      claimSrc    = bestIdx;
      claimLevel  = bestLvl;
      claimVector = VW'(VEC_BASE) + VW'(bestIdx) * VW'(VEC_STRIDE);
    end
  end

  always_comb begin
    ipiAck = '0;
    if (strobe.takeIpi) begin
      if (ipiReq[IPI_SHOOT]) ipiAck[IPI_SHOOT]   = 1'b1;
      else                   ipiAck[IPI_BARRIER] = 1'b1;
    end
  end
endmodule

// File: rtl/bnd_control.sv
module bnd_control
  import bnd_pkg::*;
(
  input  logic       boundary,
  input  logic       queuedEvent,
  input  logic       mchkReq,
  input  logic       handlerMode,
  input  logic       anyDeliverable,
  input  logic       anyIpi,
  output bndStrobe_t strobe,
  output logic       resvClear,
  output logic       flush,
  output logic       advance
);
  always_comb begin
    strobe  = '0;
    advance = 1'b0;
    if (boundary) begin
      if (queuedEvent) begin
        strobe.takeFault = 1'b1;
      end else if (mchkReq) begin
        strobe.takeMchk = 1'b1;
      end else if (!handlerMode && anyDeliverable) begin
        strobe.takeInt = 1'b1;
      end else begin
        advance = 1'b1;
        if (!handlerMode && anyIpi) strobe.takeIpi = 1'b1;
      end
    end
  end

  assign flush     = strobe.takeMchk | strobe.takeInt;
  assign resvClear = strobe.takeMchk | strobe.takeInt;
endmodule

// File: rtl/boundary_irq_ctrl.sv
module boundary_irq_ctrl
  import bnd_pkg::*;
#(
  parameter int NSRC       = 8,
  parameter int LW         = 5,
  parameter int VW         = 12,
  parameter int VEC_BASE   = 256,
  parameter int VEC_STRIDE = 16,
  parameter int SW         = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               boundary,
  input  logic               queuedEvent,
  input  logic [NSRC-1:0]    srcRaise,
  input  logic [NSRC*LW-1:0] srcLevel,
  input  logic [LW-1:0]      curLevel,
  input  logic               handlerMode,
  input  logic               mchkReq,
  input  logic [1:0]         ipiReq,
  output logic               faultDeliver,
  output logic               mchkTaken,
  output logic               intTaken,
  output logic [SW-1:0]      claimSrc,
  output logic [LW-1:0]      claimLevel,
  output logic [VW-1:0]      claimVector,
  output logic [1:0]         ipiAck,
  output logic               resvClear,
  output logic               flush,
  output logic               advance
);
  bndStrobe_t strobe;
  logic       anyDeliverable;
  logic       anyIpi;

  bnd_control u_ctl (
    .boundary      (boundary),
    .queuedEvent   (queuedEvent),
    .mchkReq       (mchkReq),
    .handlerMode   (handlerMode),
    .anyDeliverable(anyDeliverable),
    .anyIpi        (anyIpi),
    .strobe        (strobe),
    .resvClear     (resvClear),
    .flush         (flush),
    .advance       (advance)
  );

  bnd_datapath #(
    .NSRC(NSRC), .LW(LW), .VW(VW),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE), .SW(SW)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .srcRaise      (srcRaise),
    .srcLevel      (srcLevel),
    .curLevel      (curLevel),
    .ipiReq        (ipiReq),
    .strobe        (strobe),
    .anyDeliverable(anyDeliverable),
    .anyIpi        (anyIpi),
    .claimSrc      (claimSrc),
    .claimLevel    (claimLevel),
    .claimVector   (claimVector),
    .ipiAck        (ipiAck)
  );

  assign faultDeliver = strobe.takeFault;
  assign mchkTaken    = strobe.takeMchk;
  assign intTaken     = strobe.takeInt;
endmodule

// File: rtl/bnd_checker.sv
module bnd_checker #(
  parameter int NSRC = 8,
  parameter int LW   = 5,
  parameter int VW   = 12,
  parameter int SW   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               boundary,
  input logic               queuedEvent,
  input logic [NSRC-1:0]    srcRaise,
  input logic [LW-1:0]      curLevel,
  input logic               handlerMode,
  input logic               mchkReq,
  input logic               faultDeliver,
  input logic               mchkTaken,
  input logic               intTaken,
  input logic [SW-1:0]      claimSrc,
  input logic [LW-1:0]      claimLevel,
  input logic [1:0]         ipiAck,
  input logic               resvClear,
  input logic               flush,
  input logic               advance
);
  assert_fault_first_R1: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && queuedEvent) |-> (faultDeliver && !mchkTaken && !intTaken
                                   && ipiAck == 2'b00 && !advance && !flush));

  assert_mchk_override_R2: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && !queuedEvent && mchkReq) |-> mchkTaken);

  assert_handler_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    handlerMode |-> (!intTaken && ipiAck == 2'b00));

  assert_above_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    intTaken |-> (claimLevel > curLevel));

  assert_take_effects_R5: assert property (@(posedge clk) disable iff (!rstN)
    (intTaken || mchkTaken) |-> (resvClear && flush && !advance));

  assert_claim_cleared_R6: assert property (@(posedge clk) disable iff (!rstN)
    (intTaken && !srcRaise[claimSrc]) |=> !(intTaken && claimSrc == $past(claimSrc)));

  assert_ipi_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ipiAck));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |-> (!advance && !flush && !resvClear && !faultDeliver
                   && !mchkTaken && !intTaken && ipiAck == 2'b00));
endmodule

bind boundary_irq_ctrl bnd_checker #(.NSRC(NSRC), .LW(LW), .VW(VW), .SW(SW)) u_chk (
  .clk(clk), .rstN(rstN), .boundary(boundary), .queuedEvent(queuedEvent),
  .srcRaise(srcRaise), .curLevel(curLevel), .handlerMode(handlerMode),
  .mchkReq(mchkReq), .faultDeliver(faultDeliver), .mchkTaken(mchkTaken),
  .intTaken(intTaken), .claimSrc(claimSrc), .claimLevel(claimLevel),
  .ipiAck(ipiAck), .resvClear(resvClear), .flush(flush), .advance(advance)
);

// File: tb/sim_boundary_irq_ctrl.sv
module sim_boundary_irq_ctrl;
  localparam int NSRC = 8;
  localparam int LW   = 5;
  localparam int VW   = 12;
  localparam int SW   = 3;
  localparam int VB   = 256;
  localparam int VS   = 16;

  logic clk = 1'b0;
  logic rstN;
  logic boundary, queuedEvent, handlerMode, mchkReq;
  logic [NSRC-1:0]    srcRaise;
  logic [NSRC*LW-1:0] srcLevel;
  logic [LW-1:0]      curLevel;
  logic [1:0]         ipiReq;
  logic faultDeliver, mchkTaken, intTaken, resvClear, flush, advance;
  logic [SW-1:0] claimSrc;
  logic [LW-1:0] claimLevel;
  logic [VW-1:0] claimVector;
  logic [1:0]    ipiAck;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit pendM [NSRC];

  always #2 clk = ~clk;

  boundary_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .boundary(boundary), .queuedEvent(queuedEvent),
    .srcRaise(srcRaise), .srcLevel(srcLevel), .curLevel(curLevel),
    .handlerMode(handlerMode), .mchkReq(mchkReq), .ipiReq(ipiReq),
    .faultDeliver(faultDeliver), .mchkTaken(mchkTaken), .intTaken(intTaken),
    .claimSrc(claimSrc), .claimLevel(claimLevel), .claimVector(claimVector),
    .ipiAck(ipiAck), .resvClear(resvClear), .flush(flush), .advance(advance)
  );

  task automatic cmp(string phase, string field, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", phase, field, act, exp);
    end
  endtask

  function automatic int lvl(int i);
    return int'(srcLevel[i*LW +: LW]);
  endfunction

  // Called just after a falling edge with inputs already set; returns at the next falling edge.
  task automatic cycle(string phase);
    int eF = 0, eM = 0, eI = 0, eS = 0, eL = 0, eV = 0, eIpi = 0, eAdv = 0, best = -1;
    #1;
    if (boundary) begin
      if (queuedEvent) eF = 1;
      else if (mchkReq) eM = 1;
      else begin
        if (!handlerMode)
          for (int i = 0; i < NSRC; i++)
            if (pendM[i] && lvl(i) > int'(curLevel) && (best < 0 || lvl(i) > lvl(best)))
              best = i;
        if (best >= 0) begin
          eI = 1; eS = best; eL = lvl(best); eV = VB + best * VS;
        end else begin
          eAdv = 1;
          if (!handlerMode && ipiReq != 2'b00) eIpi = ipiReq[0] ? 1 : 2;
        end
      end
    end
    cmp(phase, "faultDeliver R1", int'(faultDeliver), eF);
    cmp(phase, "mchkTaken R2", int'(mchkTaken), eM);
    cmp(phase, "intTaken R3", int'(intTaken), eI);
    cmp(phase, "claimSrc R4", int'(claimSrc), eS);
    cmp(phase, "claimLevel R4", int'(claimLevel), eL);
    cmp(phase, "claimVector R4", int'(claimVector), eV);
    cmp(phase, "flush R5", int'(flush), (eI | eM));
    cmp(phase, "resvClear R5", int'(resvClear), (eI | eM));
    cmp(phase, "advance R9", int'(advance), eAdv);
    cmp(phase, "ipiAck R7", int'(ipiAck), eIpi);
    @(posedge clk);
    if (!rstN) for (int i = 0; i < NSRC; i++) pendM[i] = 0;
    else begin
      if (eI) pendM[eS] = 0;
      for (int i = 0; i < NSRC; i++) if (srcRaise[i]) pendM[i] = 1;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    boundary = 0; queuedEvent = 0; handlerMode = 0; mchkReq = 0;
    srcRaise = '0; ipiReq = 2'b00;
  endtask

  task automatic setLvl(int i, int v);
    srcLevel[i*LW +: LW] = LW'(v);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 0; idle(); srcLevel = '0; curLevel = '0;
    for (int i = 0; i < NSRC; i++) pendM[i] = 0;
    @(negedge clk);
    srcRaise = '1;
    repeat (3) cycle("reset R10");
    rstN = 1; srcRaise = '0;
    for (int i = 0; i < NSRC; i++) setLvl(i, 31);
    boundary = 1;
    cycle("after reset R10");

    // R8: raises latch, nothing decided off-boundary
    idle(); setLvl(2, 10); srcRaise[2] = 1; queuedEvent = 1; mchkReq = 1; ipiReq = 2'b11;
    cycle("no boundary R8");
    // R1: queued fault first
    idle(); boundary = 1; queuedEvent = 1; mchkReq = 1; ipiReq = 2'b01;
    cycle("queued first R1");
    // R4: level order and tie to lowest index
    idle(); setLvl(3, 9); setLvl(5, 9); srcRaise[3] = 1; srcRaise[5] = 1;
    cycle("raise R8");
    boundary = 1; cycle("highest R4");
    cycle("tie low index R4");
    cycle("last one R6");
    cycle("drained R9");
    // R3: level must be strictly above, and handler mode masks
    idle(); curLevel = 9; setLvl(6, 9); srcRaise[6] = 1;
    cycle("raise R3");
    boundary = 1; cycle("equal level R3");
    curLevel = 8; handlerMode = 1; ipiReq = 2'b10;
    cycle("handler mask R3");
    // R2: machine check overrides handler mode
    mchkReq = 1; cycle("mchk in handler R2");
    // R6: raise during claim keeps it pending
    idle(); boundary = 1; curLevel = 8; srcRaise[6] = 1;
    cycle("raise in claim R6");
    srcRaise = '0; cycle("reclaim R6");
    cycle("cleared R6");
    // R7: IPI ordering
    ipiReq = 2'b11; cycle("ipi shootdown R7");
    ipiReq = 2'b10; cycle("ipi barrier R7");

    for (int n = 0; n < 4000; n++) begin
      boundary    = ($urandom_range(0, 3) != 0);
      queuedEvent = ($urandom_range(0, 9) == 0);
      mchkReq     = ($urandom_range(0, 15) == 0);
      handlerMode = ($urandom_range(0, 5) == 0);
      ipiReq      = 2'($urandom_range(0, 3));
      srcRaise    = NSRC'($urandom) & NSRC'($urandom);
      curLevel    = LW'($urandom_range(0, 20));
      if (n % 50 == 0) for (int i = 0; i < NSRC; i++) setLvl(i, $urandom_range(0, 31));
      cycle("random R4");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule